// File: doc/BRIEF.md
# Multiply Special-Operand Resolver

This combinational block sits in front of a double-precision multiplier and inspects both operands before any mantissa work starts. When either operand is a NaN, an infinity or a zero, the product is fully known from the operand classes alone. The block raises a bypass flag and presents the finished 64-bit result, together with any invalid-operation indication.

For every pair of finite, non-zero operands the bypass flag stays low and the multiplier datapath owns the result. This includes pairs where one or both operands are subnormal. NaN selection follows a fixed order that favours the first operand. A signaling NaN in the second operand only matters when the first operand is a quiet NaN. An invalid-trap enable decides between two outcomes. With the trap disabled the block reports a flag and returns a quiet NaN. With the trap enabled it raises a trap request and writes no result.

Operand encoding is IEEE-754 binary64. The sign is bit 63 and the exponent is bits 62:52. The fraction is bits 51:0, and bit 51 is the quiet bit.

Top module: `mul_special_resolve`

## Requirements
- R1: Every generated infinity, zero or default NaN carries the XOR of the two operand sign bits in bit 63.
- R2: Infinity times zero, in either order, with trap_en low gives bypass=1, invalid_set=1, invalid_trap=0. The result is exponent all ones with only fraction bit 51 set, and its sign is the XOR sign.
- R3: An invalid case with trap_en high gives bypass=1, invalid_trap=1, invalid_set=0 and result all zeros. A valid case with trap_en high never raises invalid_trap.
- R4: Infinity times a finite non-zero operand, subnormals included, gives a signed infinity with no flag set.
- R5: A signaling NaN first operand (exponent all ones, fraction non-zero, bit 51 clear) is returned with bit 51 set and invalid_set=1. This holds whatever the second operand is.
- R6: A quiet first-operand NaN with a signaling second-operand NaN returns the second operand with bit 51 set, and invalid_set=1.
- R7: A quiet first-operand NaN with a second operand that is not a signaling NaN returns the first operand bit for bit, with no flag set.
- R8: When only the second operand is a NaN, it is returned with bit 51 forced to 1. invalid_set rises only if the NaN was signaling. An infinite first operand does not change this.
- R9: A zero operand (exponent and fraction all zero) times a finite operand gives a signed zero with no flag set.
- R10: Two finite non-zero operands, subnormals included, give bypass=0, result all zeros and both flags low.
- R11: With trap_en high, every case that would set invalid_set instead raises invalid_trap with result all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | First multiplicand, binary64 |
| op_b | input | 64 | Second multiplicand, binary64 |
| trap_en | input | 1 | Invalid-operation trap enable |
| bypass | output | 1 | Product settled here; datapath result unused |
| result | output | 64 | Settled product when bypass is high |
| invalid_set | output | 1 | Invalid-operation flag request |
| invalid_trap | output | 1 | Invalid-operation trap request |

## Verification
Two functions can meet on the same operand pair: NaN selection and invalid signalling. For example, a quiet first NaN can be paired with a signaling second NaN, or a signaling first NaN with a signaling second NaN. The vectors drive these pairs with trap_en both low and high. They judge which operand's payload emerges, that it has been quieted, and that exactly one of the flag and the trap is raised. A second overlap is an infinity paired with a NaN. That case must resolve as NaN propagation rather than as the infinity rule.

// File: rtl/mul_sr_pkg.sv
package mul_sr_pkg;
   // Class of one operand as seen by the resolver
   typedef struct packed {
      logic sign;
      logic nan;
      logic snan;
      logic inf;
      logic zero;
   } opclass_t;
endpackage

// File: rtl/mul_sr_classify.sv
module mul_sr_classify
   import mul_sr_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int WIDTH = 1 + EXP_W + FRAC_W
) (
   input  logic [WIDTH-1:0] op,
   output opclass_t         cls
);
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_ones, exp_zero, frac_zero;

   assign exp_f     = op[WIDTH-2 -: EXP_W];
   assign frac_f    = op[FRAC_W-1:0];
   assign exp_ones  = &exp_f;
   assign exp_zero  = ~|exp_f;
   assign frac_zero = ~|frac_f;

   always_comb begin
      cls.sign = op[WIDTH-1];
      cls.nan  = exp_ones & ~frac_zero;
      cls.snan = exp_ones & ~frac_zero & ~frac_f[FRAC_W-1];
      cls.inf  = exp_ones & frac_zero;
      cls.zero = exp_zero & frac_zero;
   end
endmodule

// File: rtl/mul_sr_decide.sv
module mul_sr_decide
   import mul_sr_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int WIDTH = 1 + EXP_W + FRAC_W
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  opclass_t         cls_a,
   input  opclass_t         cls_b,
   input  logic             trap_en,
   output logic             bypass,
   output logic [WIDTH-1:0] result,
   output logic             invalid_set,
   output logic             invalid_trap
);
   localparam logic [WIDTH-1:0] QUIET_MASK = {{(1+EXP_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
   localparam logic [EXP_W-1:0] EXP_MAX    = {EXP_W{1'b1}};

   logic             psign;
   logic             invalid;
   logic [WIDTH-1:0] raw;

   assign psign = cls_a.sign ^ cls_b.sign;

   always_comb begin
      bypass  = 1'b1;
      invalid = 1'b0;
      raw     = '0;
      if (cls_a.nan) begin
         if (cls_a.snan) begin
            invalid = 1'b1;
            raw     = op_a | QUIET_MASK;
         end else if (cls_b.snan) begin
            invalid = 1'b1;
            raw     = op_b | QUIET_MASK;
         end else begin
            raw     = op_a;
         end
      end else if (cls_b.nan) begin
         invalid = cls_b.snan;
         raw     = op_b | QUIET_MASK;
      end else if (cls_a.inf || cls_b.inf) begin
         if (cls_a.zero || cls_b.zero) begin
            invalid = 1'b1;
            raw     = {psign, EXP_MAX, 1'b1, {(FRAC_W-1){1'b0}}};
         end else begin
            raw     = {psign, EXP_MAX, {FRAC_W{1'b0}}};
         end
      end else if (cls_a.zero || cls_b.zero) begin
         raw = {psign, {(WIDTH-1){1'b0}}};
      end else begin
         bypass = 1'b0;
      end
   end

   always_comb begin
      invalid_set  = invalid & ~trap_en;
      invalid_trap = invalid & trap_en;
      result       = (invalid & trap_en) ? '0 : raw;
   end
endmodule

// File: rtl/mul_special_resolve.sv
module mul_special_resolve
   import mul_sr_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int WIDTH = 1 + EXP_W + FRAC_W,
   localparam int N_OPS = 2
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             trap_en,
   output logic             bypass,
   output logic [WIDTH-1:0] result,
   output logic             invalid_set,
   output logic             invalid_trap
);
   if (EXP_W < 2) begin : g_bad_exp
      $error("EXP_W must be at least 2");
   end
   if (FRAC_W < 2) begin : g_bad_frac
      $error("FRAC_W must be at least 2 to hold a quiet bit and payload");
   end

   logic [WIDTH-1:0] ops [N_OPS];
   opclass_t         cls [N_OPS];

   assign ops[0] = op_a;
   assign ops[1] = op_b;

   for (genvar i = 0; i < N_OPS; i++) begin : g_cls
      mul_sr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
         .op  (ops[i]),
         .cls (cls[i])
      );
   end

   mul_sr_decide #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_decide (
      .op_a         (op_a),
      .op_b         (op_b),
      .cls_a        (cls[0]),
      .cls_b        (cls[1]),
      .trap_en      (trap_en),
      .bypass       (bypass),
      .result       (result),
      .invalid_set  (invalid_set),
      .invalid_trap (invalid_trap)
   );
endmodule

// File: rtl/mul_special_resolve_chk.sv
module mul_special_resolve_chk #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int WIDTH = 1 + EXP_W + FRAC_W
) (
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic             trap_en,
   input logic             bypass,
   input logic [WIDTH-1:0] result,
   input logic             invalid_set,
   input logic             invalid_trap
);
   logic a_fin_nz, b_fin_nz, res_inf, res_nan;

   assign a_fin_nz = ~&op_a[WIDTH-2 -: EXP_W] & |op_a[WIDTH-2:0];
   assign b_fin_nz = ~&op_b[WIDTH-2 -: EXP_W] & |op_b[WIDTH-2:0];
   assign res_inf  = &result[WIDTH-2 -: EXP_W] & ~|result[FRAC_W-1:0];
   assign res_nan  = &result[WIDTH-2 -: EXP_W] & |result[FRAC_W-1:0];

   always_comb begin
      // R3, R11: flag and trap never together, and each follows trap_en
      p_flag_trap_excl_r3: assert (!(invalid_set && invalid_trap))
         else $error("flag and trap raised together");
      p_trap_gated_r11: assert (!(invalid_trap && !trap_en) && !(invalid_set && trap_en))
         else $error("invalid signal disagrees with trap_en");
      // R11: a trap request writes no result
      p_trap_no_result_r11: assert (!invalid_trap || (bypass && result == '0))
         else $error("trap with a result written");
      // R10: finite non-zero pairs go to the datapath
      p_no_bypass_finite_r10: assert (!(a_fin_nz && b_fin_nz) || (!bypass && !invalid_set && !invalid_trap))
         else $error("bypass on finite non-zero pair");
      // R1: a bypassed infinity carries the XOR sign
      p_inf_sign_r1: assert (!(bypass && res_inf) || (result[WIDTH-1] == (op_a[WIDTH-1] ^ op_b[WIDTH-1])))
         else $error("infinity sign wrong");
      // R5, R8: any NaN handed out is quiet
      p_nan_quiet_r5: assert (!(bypass && res_nan) || result[FRAC_W-1])
         else $error("signaling NaN returned");
   end
endmodule

bind mul_special_resolve mul_special_resolve_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
   .op_a         (op_a),
   .op_b         (op_b),
   .trap_en      (trap_en),
   .bypass       (bypass),
   .result       (result),
   .invalid_set  (invalid_set),
   .invalid_trap (invalid_trap)
);

// File: tb/mul_special_resolve_tb.sv
module mul_special_resolve_tb;
   localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
   localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
   localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
   localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
   localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
   localparam logic [63:0] NONE = 64'hBFF0_0000_0000_0000;
   localparam logic [63:0] DEN  = 64'h0000_0000_0000_0001;
   localparam logic [63:0] DQN  = 64'hFFF8_0000_0000_0000;
   localparam logic [63:0] SA   = 64'h7FF0_0000_0000_0123;
   localparam logic [63:0] SAQ  = 64'h7FF8_0000_0000_0123;
   localparam logic [63:0] QA   = 64'h7FF8_0000_0000_0456;
   localparam logic [63:0] SB   = 64'hFFF4_0000_0000_0000;
   localparam logic [63:0] SBQ  = 64'hFFFC_0000_0000_0000;
   localparam int NV = 23;

   // a, b, trap_en, expected result, {bypass, invalid_set, invalid_trap}, requirement
   localparam logic [63:0] VA [NV] = '{ONE, DEN, PINF, NONE, NINF, PINF, PZ, PINF, SA, QA, QA, QA,
                                        ONE, ONE, NONE, NZ, SA, ONE, SA, PINF, NZ, PINF, PZ};
   localparam logic [63:0] VB [NV] = '{ONE, NONE, ONE, PINF, DEN, NZ, NINF, PZ, ONE, SB, ONE, DQN,
                                        SB, DQN, PZ, NZ, ONE, SB, SB, QA, PINF, ONE, QA};
   localparam logic        VT [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0,
                                        0, 0, 0, 0, 1, 1, 0, 0, 0, 1, 1};
   localparam logic [63:0] VR [NV] = '{PZ, PZ, PINF, NINF, NINF, DQN, DQN, PZ, SAQ, SBQ, QA, QA,
                                        SBQ, DQN, NZ, PZ, PZ, PZ, SAQ, QA, DQN, PINF, QA};
   localparam logic [2:0]  VF [NV] = '{3'b000, 3'b000, 3'b100, 3'b100, 3'b100, 3'b110, 3'b110, 3'b101,
                                        3'b110, 3'b110, 3'b100, 3'b100, 3'b110, 3'b100, 3'b100, 3'b100,
                                        3'b101, 3'b101, 3'b110, 3'b100, 3'b110, 3'b100, 3'b100};
   // requirement tags: R10 R10 R4 R1 R4 R2 R2 R3 R5 R6 R7 R7 R8 R8 R9 R9 R11 R11 R5 R8 R2 R3 R8
   localparam int          VQ [NV] = '{10, 10, 4, 1, 4, 2, 2, 3, 5, 6, 7, 7, 8, 8, 9, 9, 11, 11, 5, 8, 2, 3, 8};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic        trap_en = 1'b0;
   logic        bypass, invalid_set, invalid_trap;
   logic [63:0] result;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   mul_special_resolve u_dut (
      .op_a (op_a), .op_b (op_b), .trap_en (trap_en),
      .bypass (bypass), .result (result),
      .invalid_set (invalid_set), .invalid_trap (invalid_trap)
   );

   task automatic check(input int req, input logic [63:0] er, input logic [2:0] ef);
      checks++;
      if (result !== er || {bypass, invalid_set, invalid_trap} !== ef) begin
         errors++;
         $display("FAIL R%0d a=%h b=%h trap=%0b: got res=%h flags=%b, expected res=%h flags=%b",
                  req, op_a, op_b, trap_en, result, {bypass, invalid_set, invalid_trap}, er, ef);
      end
   endtask

   task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic t);
      @(posedge clk);
      op_a = a; op_b = b; trap_en = t;
      @(negedge clk);
   endtask

   initial begin
      // Reset state: zero operands give +0 bypass, no flags (R9)
      repeat (3) @(negedge clk);
      check(9, PZ, 3'b100);
      rst = 1'b0;
      for (int i = 0; i < NV; i++) begin
         apply(VA[i], VB[i], VT[i]);
         check(VQ[i], VR[i], VF[i]);
      end
      // R1: negative zero times positive infinity gives negative default NaN
      apply(NZ, PINF, 1'b0);
      check(1, DQN, 3'b110);
      // R10: subnormal times subnormal stays in the datapath
      apply(DEN, 64'h8000_0000_0000_0007, 1'b1);
      check(10, PZ, 3'b000);
      // R4: negative infinity times negative finite gives positive infinity
      apply(NINF, NONE, 1'b0);
      check(4, PINF, 3'b100);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule